// File: doc/BRIEF.md
# Priority Interrupt Pending Arbiter

This block picks, for each of the CPUs, the interrupt that is enabled, pending for that CPU, and has the numerically smallest priority value. It then decides whether that CPU's request line is raised. The result goes through two gates. A programmable per-CPU mask limits which priorities may be reported at all. The CPU's running priority then limits which of the reported interrupts may actually interrupt it. A reserved ID, 1023, stands for "nothing to report".

The IDs are scanned a fixed number per clock (`LANES`), so one full pass takes `NIRQ/LANES` cycles. Any change on any input starts a new pass. A change during a pass restarts it. The two outputs of every CPU change together, only on the edge at which a pass completes. `busy` is high while a pass is running. No handshake applies: inputs are level state and the outputs stay valid until the next pass completes.

Top module: `pia_arbiter`

## Requirements
- R1: While reset is held and after it is released, until the first pass completes, `busy` is 0, each `irq_req` bit is 0, and each `cur_id` field (CPU c at bits c*10 +: 10) is 1023.
- R2: A candidate for CPU c is an ID i with `irq_en[i]` = 1 and `irq_pend[c*NIRQ+i]` = 1. The reported ID is the candidate whose priority value is numerically smallest. An ID pending only for the other CPU is not a candidate.
- R3: When candidates have equal priority values, the lowest ID wins.
- R4: With no candidate, `cur_id` is 1023 and `irq_req` is 0. Whenever `irq_req` is 1, `cur_id` is not 1023.
- R5: The winner is reported only if its priority is less than or equal to `prio_mask[c*8 +: 8]`. Otherwise `cur_id` is 1023 and `irq_req` is 0.
- R6: `irq_req[c]` is 1 only if the reported winner's priority is strictly less than `run_prio[c*9 +: 9]`. The value 0x100 means the CPU is idle. When the priority equals the running priority, the ID is still reported but the request stays 0.
- R7: If `dist_en` is 0 or `cpu_en[c]` is 0, CPU c reports 1023 with `irq_req[c]` = 0.
- R8: IDs below `NBANK` (32) take their priority from `prio_banked[(c*NBANK+i)*8 +: 8]`, separately per CPU. IDs at `NBANK` and above share `prio_shared[(i-NBANK)*8 +: 8]`.
- R9: On the first edge that sees an input change, `busy` rises. The outputs update, and `busy` falls, `NIRQ/LANES` edges later (8 by default) if no further change arrives. A further change restarts that count. Outputs never change while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NCPU | Per-CPU interface enable |
| irq_en | input | NIRQ | Per-ID enable |
| irq_pend | input | NCPU*NIRQ | Pending bits, CPU c at c*NIRQ + ID |
| prio_banked | input | NCPU*NBANK*8 | Per-CPU priorities for the low IDs |
| prio_shared | input | (NIRQ-NBANK)*8 | Shared priorities for the high IDs |
| prio_mask | input | NCPU*8 | Per-CPU priority mask |
| run_prio | input | NCPU*9 | Per-CPU running priority, 0x100 = idle |
| cur_id | output | NCPU*10 | Per-CPU current pending ID, 1023 = none |
| irq_req | output | NCPU | Per-CPU interrupt request |
| busy | output | 1 | A pass is in progress |

## Verification
The output checks are qualified by "no pass running and no input change this cycle". Under that condition the inputs are known to equal the values the last pass scanned. The assertions therefore assume that inputs are level state which the environment holds for at least one full pass before it relies on a result. The stimulus always holds each input pattern for longer than a pass. One scenario deliberately changes inputs in the middle of a pass, to exercise the restart. The reference model in the bench follows the same change, count and publish timing, so the outputs are compared on every cycle rather than only after settling.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  localparam logic [ID_W-1:0]  NONE_ID  = 10'd1023;
  localparam logic [RUN_W-1:0] SENTINEL = 9'h100;
endpackage

// File: rtl/pia_change_det.sv
module pia_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         chg
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= din;
  end

  assign chg = (din != prev);
endmodule

// File: rtl/pia_scan_seq.sv
module pia_scan_seq #(
  parameter int NSTEP  = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic              active,
  output logic              last,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
    end else if (restart) begin
      active <= 1'b1;
      step   <= '0;
    end else if (active) begin
      if (step == LAST_STEP) begin
        active <= 1'b0;
        step   <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign last = active && (step == LAST_STEP);

  // R9: the step counter never runs past the final chunk
  p_step_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (step <= LAST_STEP));

  // R9: an idle sequencer with no restart stays idle
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !restart) |=> !active);
endmodule

// File: rtl/pia_cpu_scan.sv
module pia_cpu_scan
  import pia_pkg::*;
#(
  parameter int NIRQ   = 64,
  parameter int NBANK  = 32,
  parameter int LANES  = 8,
  parameter int STEP_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic                        active,
  input  logic                        last,
  input  logic [STEP_W-1:0]           step,
  input  logic [NIRQ-1:0]             en,
  input  logic [NIRQ-1:0]             pend,
  input  logic [NBANK*PRIO_W-1:0]     prio_b,
  input  logic [(NIRQ-NBANK)*PRIO_W-1:0] prio_s,
  input  logic                        dist_en,
  input  logic                        cpu_en,
  input  logic [PRIO_W-1:0]           mask,
  input  logic [RUN_W-1:0]            run,
  output logic [ID_W-1:0]             cur_id,
  output logic                        req
);
  localparam int IDX_W = $clog2(NIRQ);

  logic [PRIO_W-1:0] prio_arr [NIRQ];

  for (genvar g = 0; g < NIRQ; g++) begin : g_prio
    if (g < NBANK) begin : g_bank
      assign prio_arr[g] = prio_b[g*PRIO_W +: PRIO_W];
    end else begin : g_share
      assign prio_arr[g] = prio_s[(g-NBANK)*PRIO_W +: PRIO_W];
    end
  end

  logic [RUN_W-1:0] best_p, nb_p;
  logic [ID_W-1:0]  best_id, nb_id;
  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  pub_id;
  logic             pub_req;

  // ascending scan of one chunk; only a strict improvement replaces
  always_comb begin
    nb_p  = best_p;
    nb_id = best_id;
    idx   = '0;
    for (int l = 0; l < LANES; l++) begin
      idx = IDX_W'(int'(step) * LANES + l);
      if (en[idx] && pend[idx] && ({1'b0, prio_arr[idx]} < nb_p)) begin
        nb_p  = {1'b0, prio_arr[idx]};
        nb_id = ID_W'(idx);
      end
    end
  end

  always_comb begin
    pub_id  = NONE_ID;
    pub_req = 1'b0;
    if (dist_en && cpu_en && (nb_p <= {1'b0, mask})) begin
      pub_id  = nb_id;
      pub_req = (nb_p < run);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_p  <= SENTINEL;
      best_id <= NONE_ID;
      cur_id  <= NONE_ID;
      req     <= 1'b0;
    end else if (restart) begin
      best_p  <= SENTINEL;
      best_id <= NONE_ID;
    end else if (active) begin
      best_p  <= nb_p;
      best_id <= nb_id;
      if (last) begin
        cur_id <= pub_id;
        req    <= pub_req;
      end
    end
  end

  logic settled;
  assign settled = !active && !restart;

  // R4: a raised request always names a real ID
  p_req_has_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (cur_id != NONE_ID));

  // R5: a reported ID never exceeds the mask
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && cur_id != NONE_ID) |-> (prio_arr[cur_id[IDX_W-1:0]] <= mask));

  // R6: a request beats the running priority strictly
  p_run_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && req) |-> ({1'b0, prio_arr[cur_id[IDX_W-1:0]]} < run));

  // R7: disabled distributor or interface reports nothing
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && (!dist_en || !cpu_en)) |-> (cur_id == NONE_ID && !req));

  // R2: a reported ID is a real candidate
  p_candidate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && cur_id != NONE_ID) |-> (en[cur_id[IDX_W-1:0]] && pend[cur_id[IDX_W-1:0]]));

  // R9: outputs hold while no pass is running
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ($stable(cur_id) && $stable(req)));
endmodule

// File: rtl/pia_arbiter.sv
module pia_arbiter
  import pia_pkg::*;
#(
  parameter int NIRQ  = 64,
  parameter int NCPU  = 2,
  parameter int NBANK = 32,
  parameter int LANES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             dist_en,
  input  logic [NCPU-1:0]                  cpu_en,
  input  logic [NIRQ-1:0]                  irq_en,
  input  logic [NCPU*NIRQ-1:0]             irq_pend,
  input  logic [NCPU*NBANK*PRIO_W-1:0]     prio_banked,
  input  logic [(NIRQ-NBANK)*PRIO_W-1:0]   prio_shared,
  input  logic [NCPU*PRIO_W-1:0]           prio_mask,
  input  logic [NCPU*RUN_W-1:0]            run_prio,
  output logic [NCPU*ID_W-1:0]             cur_id,
  output logic [NCPU-1:0]                  irq_req,
  output logic                             busy
);
  localparam int NSTEP  = NIRQ / LANES;
  localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam int SNAP_W = 1 + NCPU + NIRQ + NCPU*NIRQ + NCPU*NBANK*PRIO_W
                        + (NIRQ-NBANK)*PRIO_W + NCPU*PRIO_W + NCPU*RUN_W;

  logic              chg, active, last;
  logic [STEP_W-1:0] step;

  pia_change_det #(.W(SNAP_W)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({dist_en, cpu_en, irq_en, irq_pend, prio_banked,
             prio_shared, prio_mask, run_prio}),
    .chg   (chg)
  );

  pia_scan_seq #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (chg),
    .active  (active),
    .last    (last),
    .step    (step)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    pia_cpu_scan #(
      .NIRQ(NIRQ), .NBANK(NBANK), .LANES(LANES), .STEP_W(STEP_W)
    ) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (chg),
      .active  (active),
      .last    (last),
      .step    (step),
      .en      (irq_en),
      .pend    (irq_pend[c*NIRQ +: NIRQ]),
      .prio_b  (prio_banked[c*NBANK*PRIO_W +: NBANK*PRIO_W]),
      .prio_s  (prio_shared),
      .dist_en (dist_en),
      .cpu_en  (cpu_en[c]),
      .mask    (prio_mask[c*PRIO_W +: PRIO_W]),
      .run     (run_prio[c*RUN_W +: RUN_W]),
      .cur_id  (cur_id[c*ID_W +: ID_W]),
      .req     (irq_req[c])
    );
  end

  assign busy = active;

  // R9: an input change makes the block busy on the next edge
  p_chg_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> busy);
endmodule

// File: tb/pia_arbiter_tb.sv
`timescale 1ns/1ps
module pia_arbiter_tb;
  localparam int NIRQ = 64, NCPU = 2, NBANK = 32, LANES = 8;
  localparam int NSTEP = NIRQ / LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_en;
  logic [NCPU-1:0] cpu_en;
  logic [NIRQ-1:0] irq_en;
  logic [NCPU*NIRQ-1:0] irq_pend;
  logic [NCPU*NBANK*8-1:0] prio_banked;
  logic [(NIRQ-NBANK)*8-1:0] prio_shared;
  logic [NCPU*8-1:0] prio_mask;
  logic [NCPU*9-1:0] run_prio;
  logic [NCPU*10-1:0] cur_id;
  logic [NCPU-1:0] irq_req;
  logic busy;

  always #2.5 clk = ~clk;

  pia_arbiter #(.NIRQ(NIRQ), .NCPU(NCPU), .NBANK(NBANK), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .irq_en(irq_en), .irq_pend(irq_pend), .prio_banked(prio_banked),
    .prio_shared(prio_shared), .prio_mask(prio_mask), .run_prio(run_prio),
    .cur_id(cur_id), .irq_req(irq_req), .busy(busy)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_id [NCPU];
  bit m_req [NCPU];
  bit m_busy;
  int m_cnt;
  logic [1500:0] snap;

  function automatic int prio_of(int c, int i);
    if (i < NBANK) return int'(prio_banked[(c*NBANK+i)*8 +: 8]);
    return int'(prio_shared[(i-NBANK)*8 +: 8]);
  endfunction

  task automatic model_pub();
    for (int c = 0; c < NCPU; c++) begin
      int bp = 256, bi = 1023;
      for (int i = 0; i < NIRQ; i++)
        if (irq_en[i] && irq_pend[c*NIRQ+i] && prio_of(c, i) < bp) begin
          bp = prio_of(c, i); bi = i;
        end
      m_id[c] = 1023; m_req[c] = 1'b0;
      if (dist_en && cpu_en[c] && bp <= int'(prio_mask[c*8 +: 8])) begin
        m_id[c] = bi;
        m_req[c] = (bp < int'(run_prio[c*9 +: 9]));
      end
    end
  endtask

  always @(posedge clk) begin
    logic [1500:0] now;
    now = 1501'({dist_en, cpu_en, irq_en, irq_pend, prio_banked,
                 prio_shared, prio_mask, run_prio});
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin m_id[c] = 1023; m_req[c] = 0; end
      m_busy = 0; m_cnt = 0; snap = '0;
    end else if (now != snap) begin
      snap = now; m_cnt = NSTEP; m_busy = 1;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 0; model_pub(); end
    end
  end

  always @(negedge clk) begin
    cycles++;
    for (int c = 0; c < NCPU; c++) begin
      checks++;
      if (int'(cur_id[c*10 +: 10]) != m_id[c] || irq_req[c] !== m_req[c]) begin
        fails++;
        $display("FAIL %s cpu%0d: id=%0d req=%0b expected id=%0d req=%0b",
                 tag, c, cur_id[c*10 +: 10], irq_req[c], m_id[c], m_req[c]);
      end
    end
    checks++;
    if (busy !== m_busy) begin
      fails++;
      $display("FAIL %s busy=%0b expected %0b", tag, busy, m_busy);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step_in();
    @(negedge clk); #1;
  endtask

  task automatic settle();
    repeat (NSTEP + 4) @(negedge clk);
    #1;
  endtask

  task automatic expect_out(int c, int id, bit rq);
    checks++;
    if (int'(cur_id[c*10 +: 10]) != id || irq_req[c] !== rq) begin
      fails++;
      $display("FAIL %s direct cpu%0d: id=%0d req=%0b expected id=%0d req=%0b",
               tag, c, cur_id[c*10 +: 10], irq_req[c], id, rq);
    end
  endtask

  task automatic set_sh(int i, int p); prio_shared[(i-NBANK)*8 +: 8] = 8'(p); endtask
  task automatic set_bk(int c, int i, int p); prio_banked[(c*NBANK+i)*8 +: 8] = 8'(p); endtask

  initial begin
    dist_en = 0; cpu_en = '0; irq_en = '0; irq_pend = '0;
    prio_banked = '0; prio_shared = '0; prio_mask = '0; run_prio = '0;
    tag = "R1";
    repeat (3) @(negedge clk);
    #1; expect_out(0, 1023, 0); expect_out(1, 1023, 0);
    rst_n = 1;
    step_in();
    expect_out(0, 1023, 0);
    // base configuration
    dist_en = 1; cpu_en = 2'b11; prio_mask = {8'hFF, 8'hFF};
    run_prio = {9'h100, 9'h100};
    prio_banked = {NCPU*NBANK{8'hF0}}; prio_shared = {(NIRQ-NBANK){8'hF0}};
    settle();

    tag = "R2";
    step_in();
    irq_en[40] = 1; irq_en[45] = 1; irq_en[50] = 0;
    set_sh(40, 8'h30); set_sh(45, 8'h10); set_sh(50, 8'h05);
    irq_pend[0*NIRQ+40] = 1; irq_pend[0*NIRQ+45] = 1; irq_pend[0*NIRQ+50] = 1;
    irq_pend[1*NIRQ+40] = 1;
    settle();
    expect_out(0, 45, 1); expect_out(1, 40, 1);

    tag = "R3";
    step_in();
    irq_pend = '0; irq_en = '0;
    irq_en[33] = 1; irq_en[60] = 1; set_sh(33, 8'h20); set_sh(60, 8'h20);
    irq_pend[60] = 1; irq_pend[33] = 1;
    settle();
    expect_out(0, 33, 1); expect_out(1, 1023, 0);

    tag = "R4";
    step_in();
    irq_pend = '0;
    settle();
    expect_out(0, 1023, 0); expect_out(1, 1023, 0);

    tag = "R5";
    step_in();
    irq_pend[33] = 1; prio_mask[7:0] = 8'h20;
    settle();
    expect_out(0, 33, 1);
    step_in();
    prio_mask[7:0] = 8'h1F;
    settle();
    expect_out(0, 1023, 0);

    tag = "R6";
    step_in();
    prio_mask[7:0] = 8'hFF; run_prio[8:0] = 9'h020;
    settle();
    expect_out(0, 33, 0);
    step_in();
    run_prio[8:0] = 9'h021;
    settle();
    expect_out(0, 33, 1);

    tag = "R7";
    step_in();
    irq_pend[NIRQ+33] = 1; dist_en = 0;
    settle();
    expect_out(0, 1023, 0); expect_out(1, 1023, 0);
    step_in();
    dist_en = 1; cpu_en = 2'b10;
    settle();
    expect_out(0, 1023, 0); expect_out(1, 33, 1);

    tag = "R8";
    step_in();
    cpu_en = 2'b11; irq_en[5] = 1;
    set_bk(0, 5, 8'h08); set_bk(1, 5, 8'h40);
    irq_pend[5] = 1; irq_pend[NIRQ+5] = 1;
    settle();
    expect_out(0, 5, 1); expect_out(1, 33, 1);

    tag = "R9";
    step_in();
    set_bk(1, 5, 8'h01);
    step_in();
    checks++;
    if (busy !== 1'b1) begin fails++; $display("FAIL R9 busy=%0b expected 1", busy); end
    expect_out(1, 33, 1);
    repeat (3) step_in();
    set_bk(1, 5, 8'h50);
    repeat (NSTEP - 1) step_in();
    expect_out(1, 33, 1);
    settle();
    expect_out(1, 33, 1); expect_out(0, 5, 1);
    step_in();
    irq_pend[NIRQ+33] = 0;
    settle();
    expect_out(1, 5, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule